// File: doc/BRIEF.md
# Page-Granular Cache Slice Mapper

This block decides which slice of a distributed, shared second-level cache should hold a given physical address. The decision is made per page: the page number (the address with its in-page offset removed) is the only part of the address that matters. Three sources can name the slice. The first is a plain modulo of the page number by the slice count. The second is a small programmable table of page-number ranges, each bound to a slice. The third is a slice field delivered with the address translation. A fourth, combined mode puts all three in a fixed order of precedence.

Software programs the method through a mode register and fills the range table through a simple write port. Requests carry an address, a translation-supplied slice and its valid flag. One cycle later the block presents the chosen slice, a code naming the method that produced it and, in range-only mode, a miss flag when no range covered the page. The default configuration uses 4 KiB pages, 16 slices and 8 range entries, all of them parameters.

Top module: `page_slice_mapper`

## Requirements
- R1: After reset the mode is bit selection (code 0), every range entry is invalid, rsp_valid is 0 and rsp_slice, rsp_src and rsp_miss are 0.
- R2: rsp_valid equals req_valid from the previous clock cycle.
- R3: In bit-selection mode (cfg_mode 0) rsp_slice equals the page number modulo the slice count, which is req_addr[15:12] by default; rsp_src is 0 and rsp_miss is 0.
- R4: The page offset req_addr[11:0] never affects any response field: all addresses in one page map to the same slice.
- R5: In range mode (cfg_mode 1) an entry covers a page when it is valid and low bound <= page number <= high bound, both bounds inclusive; the covering entry with the lowest index supplies rsp_slice, and rsp_src is 1.
- R6: In range mode, when no valid entry covers the page, rsp_miss is 1, rsp_src is 0 and rsp_slice is the bit-selection result.
- R7: In translation mode (cfg_mode 2) rsp_slice equals req_tlb_slice and rsp_src is 2, whatever the address, the range table and req_tlb_vld hold.
- R8: In combined mode (cfg_mode 3) the translation slice wins when req_tlb_vld is 1 (src 2), otherwise the lowest covering range entry (src 1), otherwise bit selection (src 0); rsp_miss stays 0.
- R9: A range-entry or mode write applies to requests presented on the following cycle and later, not to a request in the same cycle; writing an entry with its valid bit 0 removes it from matching.
- R10: While req_valid is 0, rsp_slice, rsp_src and rsp_miss keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_we | input | 1 | Write strobe for the mode register |
| cfg_mode | input | 2 | Mode: 0 bit select, 1 range, 2 translation, 3 combined |
| rgn_we | input | 1 | Write strobe for one range entry |
| rgn_idx | input | 3 | Index of the entry written |
| rgn_valid | input | 1 | Valid bit written to the entry |
| rgn_lo | input | 20 | Inclusive low page-number bound |
| rgn_hi | input | 20 | Inclusive high page-number bound |
| rgn_slice | input | 4 | Slice bound to the entry |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Physical address |
| req_tlb_slice | input | 4 | Slice field delivered with the translation |
| req_tlb_vld | input | 1 | Translation slice field is meaningful |
| rsp_valid | output | 1 | Response present |
| rsp_slice | output | 4 | Chosen slice |
| rsp_src | output | 2 | Method used: 0 bit select, 1 range, 2 translation |
| rsp_miss | output | 1 | Range mode found no covering entry |

## Verification
The bench aims at inclusive range edges (a page exactly at a low or high bound, one past the high bound), overlapping entries where a wrong priority encoder would return the higher-index slice, and a write issued in the same cycle as a request, where a design that bypasses the write would report the new slice one cycle early. It also drives translation mode with the valid flag low, where a design that honoured the flag would fall back to the address, and idle cycles, where a design without an output enable would let the response fields drift. Random traffic then mixes mode and entry rewrites with requests over a narrow page range so that hits, misses and overlaps all occur often.

// File: rtl/page_slice_pkg.sv
package page_slice_pkg;

  typedef enum logic [1:0] {
    MAP_BITSEL   = 2'd0,
    MAP_REGION   = 2'd1,
    MAP_TLB      = 2'd2,
    MAP_COMBINED = 2'd3
  } map_mode_e;

  typedef enum logic [1:0] {
    SRC_BITSEL = 2'd0,
    SRC_REGION = 2'd1,
    SRC_TLB    = 2'd2
  } map_src_e;

endpackage

// File: rtl/psm_rst_sync.sv
module psm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/psm_region_table.sv
module psm_region_table #(
  parameter int PN_W        = 20,
  parameter int SLICE_W     = 4,
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic [PN_W-1:0]    wr_lo,
  input  logic [PN_W-1:0]    wr_hi,
  input  logic [SLICE_W-1:0] wr_slice,
  input  logic [PN_W-1:0]    lookup_pn,
  output logic               hit,
  output logic [SLICE_W-1:0] hit_slice
);
  logic [NUM_REGIONS-1:0] match;
  logic [SLICE_W-1:0]     ent_slice [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_ent
    logic               sel;
    logic               vld_q, vld_d;
    logic [PN_W-1:0]    lo_q, lo_d, hi_q, hi_d;
    logic [SLICE_W-1:0] sl_q, sl_d;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      vld_d = vld_q;
      lo_d  = lo_q;
      hi_d  = hi_q;
      sl_d  = sl_q;
      if (sel) begin
        vld_d = wr_valid;
        lo_d  = wr_lo;
        hi_d  = wr_hi;
        sl_d  = wr_slice;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
        sl_q <= sl_d;
      end
    end

    assign match[g]     = vld_q && (lo_q <= lookup_pn) && (lookup_pn <= hi_q);
    assign ent_slice[g] = sl_q;
  end

  // lowest index wins: scan downward so the last override is index 0
  always_comb begin
    hit       = 1'b0;
    hit_slice = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit       = 1'b1;
        hit_slice = ent_slice[i];
      end
    end
  end
endmodule

// File: rtl/psm_slice_select.sv
module psm_slice_select
  import page_slice_pkg::*;
#(
  parameter int PN_W       = 20,
  parameter int NUM_SLICES = 16,
  localparam int SLICE_W   = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  map_mode_e          mode,
  input  logic [PN_W-1:0]    pn,
  input  logic [SLICE_W-1:0] tlb_slice,
  input  logic               tlb_vld,
  input  logic               rgn_hit,
  input  logic [SLICE_W-1:0] rgn_slice,
  output logic [SLICE_W-1:0] slice,
  output logic [1:0]         src,
  output logic               miss
);
  logic [SLICE_W-1:0] bs_slice;

  if ((NUM_SLICES & (NUM_SLICES - 1)) == 0) begin : g_pow2
    assign bs_slice = pn[SLICE_W-1:0];
  end else begin : g_mod
    localparam logic [PN_W-1:0] NS = PN_W'(NUM_SLICES);
    logic [PN_W-1:0] rem;
    assign rem      = pn % NS;
    assign bs_slice = rem[SLICE_W-1:0];
  end

  always_comb begin
    slice = bs_slice;
    src   = SRC_BITSEL;
    miss  = 1'b0;
    unique case (mode)
      MAP_BITSEL: ;
      MAP_REGION: begin
        if (rgn_hit) begin
          slice = rgn_slice;
          src   = SRC_REGION;
        end else begin
          miss  = 1'b1;
        end
      end
      MAP_TLB: begin
        slice = tlb_slice;
        src   = SRC_TLB;
      end
      MAP_COMBINED: begin
        if (tlb_vld) begin
          slice = tlb_slice;
          src   = SRC_TLB;
        end else if (rgn_hit) begin
          slice = rgn_slice;
          src   = SRC_REGION;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/page_slice_mapper.sv
module page_slice_mapper
  import page_slice_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int NUM_SLICES  = 16,
  parameter int NUM_REGIONS = 8,
  localparam int PN_W       = ADDR_W - PAGE_BITS,
  localparam int SLICE_W    = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode_we,
  input  logic [1:0]         cfg_mode,
  input  logic               rgn_we,
  input  logic [IDX_W-1:0]   rgn_idx,
  input  logic               rgn_valid,
  input  logic [PN_W-1:0]    rgn_lo,
  input  logic [PN_W-1:0]    rgn_hi,
  input  logic [SLICE_W-1:0] rgn_slice,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SLICE_W-1:0] req_tlb_slice,
  input  logic               req_tlb_vld,
  output logic               rsp_valid,
  output logic [SLICE_W-1:0] rsp_slice,
  output logic [1:0]         rsp_src,
  output logic               rsp_miss
);
  logic               rst_int_n;
  map_mode_e          mode_q, mode_d;
  logic [PN_W-1:0]    req_pn;
  logic               tbl_hit;
  logic [SLICE_W-1:0] tbl_slice;
  logic [SLICE_W-1:0] sel_slice;
  logic [1:0]         sel_src;
  logic               sel_miss;
  logic               vld_d;
  logic [SLICE_W-1:0] slice_d;
  logic [1:0]         src_d;
  logic               miss_d;

  psm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign req_pn = req_addr[ADDR_W-1:PAGE_BITS];

  // mode register
  always_comb begin
    mode_d = mode_q;
    if (cfg_mode_we) mode_d = map_mode_e'(cfg_mode);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= MAP_BITSEL;
    else            mode_q <= mode_d;
  end

  psm_region_table #(
    .PN_W        (PN_W),
    .SLICE_W     (SLICE_W),
    .NUM_REGIONS (NUM_REGIONS)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (rgn_we),
    .wr_idx    (rgn_idx),
    .wr_valid  (rgn_valid),
    .wr_lo     (rgn_lo),
    .wr_hi     (rgn_hi),
    .wr_slice  (rgn_slice),
    .lookup_pn (req_pn),
    .hit       (tbl_hit),
    .hit_slice (tbl_slice)
  );

  psm_slice_select #(
    .PN_W       (PN_W),
    .NUM_SLICES (NUM_SLICES)
  ) u_select (
    .mode      (mode_q),
    .pn        (req_pn),
    .tlb_slice (req_tlb_slice),
    .tlb_vld   (req_tlb_vld),
    .rgn_hit   (tbl_hit),
    .rgn_slice (tbl_slice),
    .slice     (sel_slice),
    .src       (sel_src),
    .miss      (sel_miss)
  );

  // response registers: fields load only with a request
  always_comb begin
    vld_d   = req_valid;
    slice_d = rsp_slice;
    src_d   = rsp_src;
    miss_d  = rsp_miss;
    if (req_valid) begin
      slice_d = sel_slice;
      src_d   = sel_src;
      miss_d  = sel_miss;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_slice <= '0;
      rsp_src   <= SRC_BITSEL;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= vld_d;
      rsp_slice <= slice_d;
      rsp_src   <= src_d;
      rsp_miss  <= miss_d;
    end
  end
endmodule

// File: rtl/page_slice_mapper_chk.sv
module page_slice_mapper_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int NUM_SLICES = 16,
  localparam int SLICE_W   = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_q,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [SLICE_W-1:0] req_tlb_slice,
  input logic               req_tlb_vld,
  input logic               rsp_valid,
  input logic [SLICE_W-1:0] rsp_slice,
  input logic [1:0]         rsp_src,
  input logic               rsp_miss
);
  logic [ADDR_W-1:0]  addr_rem;
  logic [SLICE_W-1:0] exp_bs;
  assign addr_rem = (req_addr >> PAGE_BITS) % ADDR_W'(NUM_SLICES);
  assign exp_bs   = addr_rem[SLICE_W-1:0];

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_bitsel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_q == 2'd0) |=>
      (rsp_slice == $past(exp_bs) && rsp_src == 2'd0 && !rsp_miss));

  assert_miss_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_q == 2'd1) |=>
      (!rsp_miss || (rsp_src == 2'd0 && rsp_slice == $past(exp_bs))));

  assert_tlb_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_q == 2'd2) |=>
      (rsp_slice == $past(req_tlb_slice) && rsp_src == 2'd2 && !rsp_miss));

  assert_combined_tlb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_q == 2'd3 && req_tlb_vld) |=>
      (rsp_slice == $past(req_tlb_slice) && rsp_src == 2'd2 && !rsp_miss));

  assert_combined_nomiss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_q == 2'd3) |=> !rsp_miss);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_slice) && $stable(rsp_src) && $stable(rsp_miss)));
endmodule

bind page_slice_mapper page_slice_mapper_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BITS  (PAGE_BITS),
  .NUM_SLICES (NUM_SLICES)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .mode_q        (mode_q),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_tlb_slice (req_tlb_slice),
  .req_tlb_vld   (req_tlb_vld),
  .rsp_valid     (rsp_valid),
  .rsp_slice     (rsp_slice),
  .rsp_src       (rsp_src),
  .rsp_miss      (rsp_miss)
);

// File: tb/page_slice_mapper_tb_top.sv
module page_slice_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode_we = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        rgn_we = 1'b0;
  logic [2:0]  rgn_idx = 3'd0;
  logic        rgn_valid = 1'b0;
  logic [19:0] rgn_lo = '0;
  logic [19:0] rgn_hi = '0;
  logic [3:0]  rgn_slice = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_tlb_slice = '0;
  logic        req_tlb_vld = 1'b0;
  logic        rsp_valid;
  logic [3:0]  rsp_slice;
  logic [1:0]  rsp_src;
  logic        rsp_miss;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of configuration
  logic [1:0]  m_mode;
  bit          m_vld [8];
  logic [19:0] m_lo  [8];
  logic [19:0] m_hi  [8];
  logic [3:0]  m_sl  [8];
  logic [3:0]  h_slice;
  logic [1:0]  h_src;
  bit          h_miss;

  always #10 clk = ~clk;

  page_slice_mapper dut_i (
    .clk (clk), .rst_n (rst_n),
    .cfg_mode_we (cfg_mode_we), .cfg_mode (cfg_mode),
    .rgn_we (rgn_we), .rgn_idx (rgn_idx), .rgn_valid (rgn_valid),
    .rgn_lo (rgn_lo), .rgn_hi (rgn_hi), .rgn_slice (rgn_slice),
    .req_valid (req_valid), .req_addr (req_addr),
    .req_tlb_slice (req_tlb_slice), .req_tlb_vld (req_tlb_vld),
    .rsp_valid (rsp_valid), .rsp_slice (rsp_slice),
    .rsp_src (rsp_src), .rsp_miss (rsp_miss)
  );

  function automatic void expect_map(input logic [1:0] md, input logic [31:0] a,
                                     input logic [3:0] ts, input bit tv,
                                     output logic [3:0] s, output logic [1:0] src,
                                     output bit miss);
    logic [19:0] pn;
    bit          hit;
    logic [3:0]  hs;
    pn  = a[31:12];
    hit = 1'b0;
    hs  = 4'd0;
    for (int i = 0; i < 8; i++) begin
      if (!hit && m_vld[i] && m_lo[i] <= pn && pn <= m_hi[i]) begin
        hit = 1'b1;
        hs  = m_sl[i];
      end
    end
    s = pn[3:0]; src = 2'd0; miss = 1'b0;
    case (md)
      2'd1: if (hit) begin s = hs; src = 2'd1; end else miss = 1'b1;
      2'd2: begin s = ts; src = 2'd2; end
      2'd3: if (tv) begin s = ts; src = 2'd2; end
            else if (hit) begin s = hs; src = 2'd1; end
      default: ;
    endcase
  endfunction

  // one cycle: drive at negedge, check at the following negedge
  task automatic step(input bit mwe, input logic [1:0] mval,
                      input bit rwe, input int ridx, input bit rv,
                      input logic [19:0] lo, input logic [19:0] hi, input logic [3:0] sl,
                      input bit qv, input logic [31:0] addr,
                      input logic [3:0] ts, input bit tv, input string tag);
    logic [3:0] es;
    logic [1:0] esrc;
    bit         emiss;
    if (qv) begin
      expect_map(m_mode, addr, ts, tv, es, esrc, emiss);
      h_slice = es; h_src = esrc; h_miss = emiss;
    end
    if (mwe) m_mode = mval;
    if (rwe) begin
      m_vld[ridx] = rv; m_lo[ridx] = lo; m_hi[ridx] = hi; m_sl[ridx] = sl;
    end
    cfg_mode_we = mwe; cfg_mode = mval;
    rgn_we = rwe; rgn_idx = 3'(ridx); rgn_valid = rv;
    rgn_lo = lo; rgn_hi = hi; rgn_slice = sl;
    req_valid = qv; req_addr = addr; req_tlb_slice = ts; req_tlb_vld = tv;
    @(posedge clk);
    @(negedge clk);
    cfg_mode_we = 1'b0; rgn_we = 1'b0; req_valid = 1'b0;
    n_tests++;
    if (rsp_valid !== qv || rsp_slice !== h_slice || rsp_src !== h_src || rsp_miss !== h_miss) begin
      n_fail++;
      $display("FAIL %s (R2 valid/%s): got v=%0b s=%0d src=%0d m=%0b exp v=%0b s=%0d src=%0d m=%0b",
               tag, qv ? "map" : "R10 hold", rsp_valid, rsp_slice, rsp_src, rsp_miss,
               qv, h_slice, h_src, h_miss);
    end
  endtask

  task automatic req(input logic [31:0] addr, input logic [3:0] ts, input bit tv, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, addr, ts, tv, tag);
  endtask

  task automatic set_mode(input logic [1:0] md, input string tag);
    step(1, md, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic set_rgn(input int idx, input bit v, input logic [19:0] lo,
                         input logic [19:0] hi, input logic [3:0] sl, input string tag);
    step(0, 0, 1, idx, v, lo, hi, sl, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_mode = 2'd0;
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0; m_sl[i] = '0;
    end
    h_slice = 4'd0; h_src = 2'd0; h_miss = 1'b0;

    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of the outputs
    n_tests++;
    if (rsp_valid !== 1'b0 || rsp_slice !== 4'd0 || rsp_src !== 2'd0 || rsp_miss !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got v=%0b s=%0d src=%0d m=%0b exp 0 0 0 0",
               rsp_valid, rsp_slice, rsp_src, rsp_miss);
    end
    req(32'h0000_5ABC, 4'd9, 1'b1, "R1 default mode is bit select");
    set_mode(2'd1, "R10 idle after mode write");
    req(32'h0001_0000, 4'd0, 1'b0, "R1 entries invalid after reset");

    // R3 and R4
    set_mode(2'd0, "R10 idle");
    req(32'h0000_5ABC, 4'd0, 1'b0, "R3 bit select");
    req(32'hFFFF_FFFF, 4'd0, 1'b0, "R3 top page");
    req(32'h1234_7000, 4'd0, 1'b0, "R4 page start");
    req(32'h1234_7FFF, 4'd0, 1'b0, "R4 page end");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, 4'd3, 1'b1, "R10 hold on idle");

    // R5 and R6: overlapping ranges, inclusive edges
    set_rgn(2, 1'b1, 20'h10, 20'h20, 4'd9, "R5 write entry 2");
    set_rgn(5, 1'b1, 20'h18, 20'h30, 4'd3, "R5 write entry 5");
    set_mode(2'd1, "R5 range mode");
    req(32'h0001_0000, 4'd0, 1'b0, "R5 low bound inclusive");
    req(32'h0002_0FFF, 4'd0, 1'b0, "R5 high bound inclusive");
    req(32'h0001_C123, 4'd0, 1'b0, "R5 lowest index wins overlap");
    req(32'h0002_1000, 4'd0, 1'b0, "R5 second entry");
    req(32'h0003_0000, 4'd0, 1'b0, "R5 second entry high bound");
    req(32'h0003_1000, 4'd0, 1'b0, "R6 miss past high bound");
    req(32'h0000_F000, 4'd0, 1'b0, "R6 miss below low bound");

    // R9: write and request in the same cycle see the old table
    step(0, 0, 1, 0, 1'b1, 20'h31, 20'h31, 4'd12, 1, 32'h0003_1000, 4'd0, 1'b0, "R9 same-cycle write not seen");
    req(32'h0003_1000, 4'd0, 1'b0, "R9 write seen next cycle");
    set_rgn(0, 1'b0, 20'h31, 20'h31, 4'd12, "R9 invalidate entry 0");
    req(32'h0003_1000, 4'd0, 1'b0, "R9 invalid entry ignored");
    step(1, 2'd2, 0, 0, 0, 0, 0, 0, 1, 32'h0001_0000, 4'd7, 1'b0, "R9 mode write same cycle");

    // R7
    req(32'h0001_0000, 4'd7, 1'b0, "R7 translation ignores flag and table");
    req(32'hFFFF_F000, 4'd14, 1'b1, "R7 translation slice");

    // R8
    set_mode(2'd3, "R8 combined mode");
    req(32'h0001_0000, 4'd5, 1'b1, "R8 translation first");
    req(32'h0001_0000, 4'd5, 1'b0, "R8 range second");
    req(32'h0050_0000, 4'd5, 1'b0, "R8 bit select fallback");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 4'd0, 1'b0, "R10 hold after combined");

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int          pick;
      bit          mwe, rwe, qv, tv;
      logic [1:0]  md;
      int          idx;
      logic [19:0] lo, hi, pn;
      logic [31:0] addr;
      pick = $urandom % 100;
      mwe  = (pick < 6);
      rwe  = (pick >= 6 && pick < 18);
      md   = 2'($urandom % 4);
      idx  = $urandom % 8;
      lo   = 20'($urandom % 256);
      hi   = lo + 20'($urandom % 48);
      qv   = ($urandom % 4) != 0;
      tv   = ($urandom % 2) != 0;
      pn   = 20'($urandom % 300);
      addr = ($urandom % 10 == 0) ? $urandom : {pn, 12'($urandom)};
      step(mwe, md, rwe, idx, ($urandom % 5) != 0, lo, hi, 4'($urandom),
           qv, addr, 4'($urandom), tv, "R5/R6/R7/R8 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule